// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects up to 32 interrupt request lines into one interrupt line for a processor. Each request line is fixed at build time as level-sensitive or edge-captured. A captured request sets a bit in a status register. The status is masked by an enable register to form the pending set. The lowest-numbered pending source is reported as a vector number, so the handler does not have to scan the bits.

Software reaches eight word registers through a simple write strobe, a byte address and a combinational read port. The registers are status, pending, enable, acknowledge, set-enable, clear-enable, vector and master control. The two low bits of the master control word have two jobs. Bit 0 gates the processor line. Bit 1 arms hardware capture, and while it is set it also locks out direct software writes to status. With bit 1 clear, software can place arbitrary patterns in status for test.

Request lines cross into the clock domain through a parameterised synchronizer of at least two flops before capture.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every register reads zero except the vector word, which reads all ones, and `irq_out` is low.
- R2: The word index is `bus_addr[5:2]`. Word 1 (pending) reads the bitwise AND of status and enable.
- R3: Word 6 (vector) reads the index of the lowest-numbered set pending bit, or all ones when no bit is pending.
- R4: `irq_out` is high exactly when bit 0 of word 7 is set and at least one pending bit is set.
- R5: A write to word 3 (acknowledge) clears each status bit whose written bit is 1. Words 3, 4 and 5 read zero.
- R6: A write to word 4 ORs the data into enable. A write to word 5 clears the enable bits where the data has ones.
- R7: While bit 1 of word 7 is set, a level-sensitive input that is high (seen after two synchronizer flops, so status shows it three clocks after the pin rises) sets its status bit on every clock. The bit stays set after the pin falls, until it is acknowledged.
- R8: While bit 1 of word 7 is set, an edge-captured input sets its status bit once per 0-to-1 transition. A line held high after acknowledge does not set it again.
- R9: While bit 1 of word 7 is clear, no input of either kind changes status.
- R10: A write to word 0 loads status only while bit 1 of word 7 is clear. Otherwise the write is ignored.
- R11: Writes to words 1, 6 and to word indices 8 to 15 change nothing. Reads of word indices 8 to 15 return zero.
- R12: Writes to word 2 (enable) and word 7 (master control) store the full 32-bit value, and it reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The assertions assume the following about the inputs:
- A write is a single-cycle pulse with a stable address and data for that cycle.
- A request line has no meaning until it has passed the synchronizer, so the checks reason about the synchronized level and never about the raw pins.

How the stimulus keeps within these assumptions:
- The random phase drives every input at the falling clock edge, so each write is exactly one sampled cycle.
- Request lines toggle one bit at a time, at random intervals.
- Addresses cover the unused word indices as well as the eight real ones.
- Master-control values are random, so capture arming, output gating and status locking are all seen in every combination.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int unsigned OFF_STATUS = 0;
   localparam int unsigned OFF_PEND   = 1;
   localparam int unsigned OFF_EN     = 2;
   localparam int unsigned OFF_ACK    = 3;
   localparam int unsigned OFF_SETEN  = 4;
   localparam int unsigned OFF_CLREN  = 5;
   localparam int unsigned OFF_VEC    = 6;
   localparam int unsigned OFF_MASTER = 7;

   localparam int unsigned MST_OUT_BIT = 0;
   localparam int unsigned MST_HW_BIT  = 1;

   typedef struct packed {
      logic st;
      logic en;
      logic ack;
      logic set;
      logic clr;
      logic mst;
   } ivc_wr_t;
endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ivc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ivc_capture.sv
module ivc_capture #(
   parameter int           W         = 32,
   parameter logic [W-1:0] EDGE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic         arm,
   output logic [W-1:0] set_mask
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_src
         if (EDGE_MASK[i]) begin : g_edge
            assign set_mask[i] = arm & lvl[i] & ~prev_q[i];
         end else begin : g_level
            assign set_mask[i] = arm & lvl[i];
         end
      end
   endgenerate

   // R8: an edge source cannot fire on two consecutive cycles
   a_r8_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_mask & EDGE_MASK) != '0) |=> ((set_mask & EDGE_MASK & $past(set_mask)) == '0));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
   parameter int W     = 32,
   parameter int VEC_W = 32
) (
   input  logic [W-1:0]     req,
   output logic [VEC_W-1:0] vec
);
   generate
      if (VEC_W < $clog2(W) + 1) begin : g_bad_vec
         $error("ivc_prio vector too narrow");
      end
   endgenerate

   always_comb begin
      vec = '1;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) vec = VEC_W'(i);
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import ivc_pkg::*;
#(
   parameter int                 N_SRC       = 32,
   parameter int                 DATA_W      = 32,
   parameter int                 ADDR_W      = 6,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [N_SRC-1:0]   EDGE_MASK   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   localparam int IDX_W = ADDR_W - 2;
   localparam int VIDX  = $clog2(N_SRC);

   generate
      if (N_SRC > DATA_W || N_SRC < 2) begin : g_bad_src
         $error("irq_vec_ctrl: N_SRC must be 2..DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("irq_vec_ctrl: ADDR_W must cover eight words");
      end
   endgenerate

   logic [IDX_W-1:0]  widx;
   logic [N_SRC-1:0]  wsrc;
   ivc_wr_t           dec;
   logic              unused_lo_bits;

   logic [N_SRC-1:0]  status_q, status_d;
   logic [N_SRC-1:0]  enable_q, enable_d;
   logic [DATA_W-1:0] mst_q, mst_d;
   logic [N_SRC-1:0]  sync_lvl, set_mask, pending;
   logic [DATA_W-1:0] vec_w;

   assign widx           = bus_addr[ADDR_W-1:2];
   assign unused_lo_bits = ^bus_addr[1:0];
   assign wsrc           = bus_wdata[N_SRC-1:0];

   always_comb begin
      dec.st  = bus_wr && (widx == IDX_W'(OFF_STATUS));
      dec.en  = bus_wr && (widx == IDX_W'(OFF_EN));
      dec.ack = bus_wr && (widx == IDX_W'(OFF_ACK));
      dec.set = bus_wr && (widx == IDX_W'(OFF_SETEN));
      dec.clr = bus_wr && (widx == IDX_W'(OFF_CLREN));
      dec.mst = bus_wr && (widx == IDX_W'(OFF_MASTER));
   end

   ivc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(sync_lvl)
   );

   ivc_capture #(.W(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
      .clk(clk), .rst_n(rst_n), .lvl(sync_lvl),
      .arm(mst_q[MST_HW_BIT]), .set_mask(set_mask)
   );

   always_comb begin
      status_d = status_q;
      if (dec.st && !mst_q[MST_HW_BIT]) status_d = wsrc;
      if (dec.ack)                      status_d = status_d & ~wsrc;
      status_d = status_d | set_mask;

      enable_d = enable_q;
      if (dec.en)  enable_d = wsrc;
      if (dec.set) enable_d = enable_q | wsrc;
      if (dec.clr) enable_d = enable_q & ~wsrc;

      mst_d = dec.mst ? bus_wdata : mst_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
         mst_q    <= '0;
      end else begin
         status_q <= status_d;
         enable_q <= enable_d;
         mst_q    <= mst_d;
      end
   end

   assign pending = status_q & enable_q;

   ivc_prio #(.W(N_SRC), .VEC_W(DATA_W)) u_prio (
      .req(pending), .vec(vec_w)
   );

   assign irq_out = mst_q[MST_OUT_BIT] & (|pending);

   always_comb begin
      bus_rdata = '0;
      unique case (widx)
         IDX_W'(OFF_STATUS): bus_rdata = DATA_W'(status_q);
         IDX_W'(OFF_PEND):   bus_rdata = DATA_W'(pending);
         IDX_W'(OFF_EN):     bus_rdata = DATA_W'(enable_q);
         IDX_W'(OFF_VEC):    bus_rdata = vec_w;
         IDX_W'(OFF_MASTER): bus_rdata = mst_q;
         default:            bus_rdata = '0;
      endcase
   end

   // R3: a reported vector names a pending source with no lower one pending
   a_r3_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_w != '1) |-> (pending[vec_w[VIDX-1:0]] &&
                         ((pending & ~({N_SRC{1'b1}} << vec_w[VIDX-1:0])) == '0)));
   // R3: nothing pending means the all-ones vector
   a_r3_vec_none: assert property (@(posedge clk) disable iff (!rst_n)
      (pending == '0) |-> (vec_w == '1));
   // R4: the line is never raised without a valid vector
   a_r4_out_vec: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (vec_w != '1));
   // R5: acknowledged bits are clear unless captured again in that cycle
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      dec.ack |=> ((status_q & $past(wsrc) & ~$past(set_mask)) == '0));
   // R6: set-enable leaves all written ones enabled
   a_r6_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
      dec.set |=> ((enable_q & $past(wsrc)) == $past(wsrc)));
   // R9: capture disarmed and no status write, so no new status bits
   a_r9_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!mst_q[MST_HW_BIT] && !dec.st) |=> ((status_q & ~$past(status_q)) == '0));
   // R10: a status write while armed adds nothing beyond captures
   a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_q[MST_HW_BIT] && dec.st) |=>
         ((status_q & ~($past(status_q) | $past(set_mask))) == '0));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
   localparam logic [31:0] EDGES = 32'hFFFF0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_vec_ctrl #(.EDGE_MASK(EDGES)) u_irq_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   // reference model built from the requirements
   logic [31:0] p1, p2, pp, m_status, m_en, m_mst;
   logic [31:0] st_n, en_n;
   always @(posedge clk) begin
      if (!rst_n) begin
         p1 <= '0; p2 <= '0; pp <= '0;
         m_status <= '0; m_en <= '0; m_mst <= '0;
      end else begin
         st_n = m_status;
         en_n = m_en;
         if (bus_wr) begin
            case (bus_addr[5:2])
               4'd0: if (!m_mst[1]) st_n = bus_wdata;
               4'd2: en_n = bus_wdata;
               4'd3: st_n = st_n & ~bus_wdata;
               4'd4: en_n = en_n | bus_wdata;
               4'd5: en_n = en_n & ~bus_wdata;
               4'd7: m_mst <= bus_wdata;
               default: ;
            endcase
         end
         if (m_mst[1]) st_n = st_n | (p2 & ~EDGES) | (p2 & ~pp & EDGES);
         m_status <= st_n;
         m_en     <= en_n;
         p1 <= irq_in; p2 <= p1; pp <= p2;
      end
   end

   function automatic logic [31:0] lowest(input logic [31:0] v);
      logic [31:0] r = 32'hFFFFFFFF;
      for (int i = 31; i >= 0; i--) if (v[i]) r = i;
      return r;
   endfunction

   function automatic logic [31:0] exp_read(input int off);
      case (off)
         0: return m_status;
         1: return m_status & m_en;
         2: return m_en;
         6: return lowest(m_status & m_en);
         7: return m_mst;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input int off);
      case (off)
         0: return "R7";
         1: return "R2";
         2: return "R6";
         3, 4, 5: return "R5";
         6: return "R3";
         7: return "R12";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int off, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'(off << 2); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int off, output logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 6'(off << 2);
      #0.5 v = bus_rdata;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      for (int o = 0; o < 8; o++) begin
         rd(o, v);
         check("R1", v, (o == 6) ? 32'hFFFFFFFF : 32'h0);
      end
      check("R1", {31'b0, irq_out}, 32'h0);

      wr(0, 32'h5);  rd(0, v); check("R10", v, 32'h5);
      wr(2, 32'h6);  rd(1, v); check("R2", v, 32'h4);
      rd(6, v); check("R3", v, 32'd2);
      check("R4", {31'b0, irq_out}, 32'h0);
      wr(7, 32'h1);  rd(7, v); check("R4", {31'b0, irq_out}, 32'h1);
      wr(3, 32'h4);  rd(0, v); check("R5", v, 32'h1);
      rd(6, v); check("R3", v, 32'hFFFFFFFF);
      check("R4", {31'b0, irq_out}, 32'h0);
      rd(3, v); check("R5", v, 32'h0);
      wr(4, 32'h1);  rd(2, v); check("R6", v, 32'h7);
      check("R4", {31'b0, irq_out}, 32'h1);
      wr(5, 32'h6);  rd(2, v); check("R6", v, 32'h1);

      // R9: disarmed capture ignores both kinds of input
      irq_in = (32'h1 << 16) | 32'h8;
      repeat (5) @(negedge clk);
      rd(0, v); check("R9", v, 32'h1);
      irq_in = '0;
      repeat (4) @(negedge clk);

      // R10: status write ignored while armed
      wr(7, 32'h3);
      wr(0, 32'hF0); rd(0, v); check("R10", v, 32'h1);
      wr(3, 32'hFFFFFFFF); rd(0, v); check("R5", v, 32'h0);

      // R7: level input, held until acknowledged, re-set while high
      irq_in = 32'h8;
      repeat (4) @(negedge clk);
      rd(0, v); check("R7", v, 32'h8);
      irq_in = '0;
      repeat (4) @(negedge clk);
      rd(0, v); check("R7", v, 32'h8);
      wr(3, 32'h8);  rd(0, v); check("R7", v, 32'h0);
      irq_in = 32'h8;
      repeat (4) @(negedge clk);
      wr(3, 32'h8);
      repeat (2) @(negedge clk);
      rd(0, v); check("R7", v, 32'h8);
      irq_in = '0;
      repeat (4) @(negedge clk);
      wr(3, 32'hFFFFFFFF);

      // R8: edge input sets once per rising transition
      irq_in = 32'h1 << 20;
      repeat (4) @(negedge clk);
      rd(0, v); check("R8", v, 32'h1 << 20);
      wr(3, 32'h1 << 20);
      repeat (3) @(negedge clk);
      rd(0, v); check("R8", v, 32'h0);
      irq_in = '0;
      repeat (3) @(negedge clk);
      irq_in = 32'h1 << 20;
      repeat (4) @(negedge clk);
      rd(0, v); check("R8", v, 32'h1 << 20);
      irq_in = '0;
      repeat (4) @(negedge clk);
      wr(3, 32'hFFFFFFFF);

      // R11: read-only and unused words
      wr(2, 32'hFFFFFFFF);
      wr(1, 32'h55); wr(6, 32'h55); wr(9, 32'h55);
      rd(0, v); check("R11", v, 32'h0);
      rd(1, v); check("R11", v, 32'h0);
      rd(6, v); check("R11", v, 32'hFFFFFFFF);
      rd(9, v); check("R11", v, 32'h0);
      rd(2, v); check("R11", v, 32'hFFFFFFFF);

      // R12: full-width storage
      wr(7, 32'hABCD0003); rd(7, v); check("R12", v, 32'hABCD0003);
      wr(2, 32'h12345678); rd(2, v); check("R12", v, 32'h12345678);

      // random phase against the reference model
      void'($urandom(32'd20240611));
      @(negedge clk);
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         check(tag_of(int'(bus_addr[5:2])), bus_rdata, exp_read(int'(bus_addr[5:2])));
         check("R4", {31'b0, irq_out},
               {31'b0, m_mst[0] && ((m_status & m_en) != 0)});
         bus_wr    = ($urandom % 4) == 0;
         bus_addr  = 6'(($urandom % 16) << 2);
         bus_wdata = $urandom;
         if (($urandom % 4) == 0) irq_in = irq_in ^ (32'h1 << ($urandom % 32));
      end
      bus_wr = 1'b0;
      finish_run();
   end
endmodule